// File: doc/BRIEF.md
# ADC Multiplexer Accumulation Sequencer

This block paces the sampling of a two-channel metering front end and marks out accumulation intervals. A one-clock-wide `tick` strobe arrives once per period of a 32768 Hz reference. Thirteen ticks make one multiplexer frame. In the first four tick slots of each frame, the block names the input to be sampled on `chan_sel` and pulses `sample_vld`. The remaining slots carry no sample.

Frames are counted and grouped into accumulation cycles. The length of an accumulation cycle, in frames, is a coded pre-sample count times a 6-bit cycle count. Both come from the control byte `ctrl`. The block emits a one-clock strobe at the end of every frame, and a second one-clock strobe when an accumulation cycle closes. Downstream arithmetic uses these strobes to pick up per-frame status and accumulated totals.

Top module: `adc_mux_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sample_vld`, `chan_sel`, `frame_irq` and `accum_irq` are all zero.
- R2: A frame spans exactly 13 ticks. `frame_irq` pulses in the clock after the 13th tick of each frame and after no other tick.
- R3: The first four ticks of a frame each produce a sample slot, in a fixed order. `chan_sel` = 0 is current B, 1 is voltage B, 2 is current A and 3 is voltage A.
- R4: `sample_vld` pulses only in the clock that follows a slot tick. Clocks without a tick produce no strobe. `chan_sel` holds its last value between slots.
- R5: `frame_irq` and `accum_irq` are each exactly one clock wide.
- R6: An accumulation cycle lasts P × S frames. S is `ctrl[5:0]`. P is decoded from `ctrl[7:6]`: 00 gives 42, 01 gives 50, 10 gives 84 and 11 gives 100.
- R7: An S field of 0 is treated as 1.
- R8: Field settings with equal products give equal lengths. For example, 00/50 and 11/21 both give 2100 frames.
- R9: `ctrl` is sampled only on the first tick of each accumulation cycle. A change made mid-cycle takes effect from the next cycle.
- R10: `accum_irq` is raised only in the same clock as the `frame_irq` that closes the last frame of an accumulation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe per 32768 Hz period |
| ctrl | input | 8 | [7:6] pre-sample code, [5:0] cycle count |
| chan_sel | output | 2 | Input being sampled in the current slot |
| sample_vld | output | 1 | Sample-slot strobe |
| frame_irq | output | 1 | End-of-frame strobe |
| accum_irq | output | 1 | End-of-accumulation strobe |

## Verification
Every output is a register that loads on the edge where `tick` is seen. So the slot strobe, channel code and both interrupts are due exactly one clock after the tick that causes them. The bench drives each tick on a falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. It also reads them in idle clocks between ticks to confirm that nothing fires there. Accumulation lengths are measured by counting `frame_irq` pulses up to each `accum_irq`, and comparing the count against a length the bench computes from its own decode table.

// File: rtl/adc_mux_seq_pkg.sv
package adc_mux_seq_pkg;
  localparam int CTRL_W = 8;
  localparam int SUM_W  = 6;
  localparam int CODE_W = CTRL_W - SUM_W;
  localparam int LEN_W  = 13;
  localparam int PRE_W  = 7;

  function automatic logic [PRE_W-1:0] pre_decode(input logic [CODE_W-1:0] code);
    logic [PRE_W-1:0] v;
    case (code)
      2'd0:    v = 7'd42;
      2'd1:    v = 7'd50;
      2'd2:    v = 7'd84;
      default: v = 7'd100;
    endcase
    return v;
  endfunction

  function automatic logic [LEN_W-1:0] accum_len(input logic [CTRL_W-1:0] c);
    logic [SUM_W-1:0] s;
    s = (c[SUM_W-1:0] == '0) ? SUM_W'(1) : c[SUM_W-1:0];
    return LEN_W'(pre_decode(c[CTRL_W-1:SUM_W])) * LEN_W'(s);
  endfunction
endpackage

// File: rtl/adc_frame_counter.sv
module adc_frame_counter #(
  parameter int TICKS  = 13,
  parameter int NUM_CH = 4,
  localparam int PH_W  = $clog2(TICKS),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic            frame_start,
  output logic            frame_end,
  output logic            slot_fire,
  output logic [CH_W-1:0] slot_ch
);
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (tick)
      phase <= (phase == PH_W'(TICKS-1)) ? '0 : phase + 1'b1;
  end

  assign frame_start = tick && (phase == '0);
  assign frame_end   = tick && (phase == PH_W'(TICKS-1));
  assign slot_fire   = tick && (phase < PH_W'(NUM_CH));
  assign slot_ch     = phase[CH_W-1:0];
endmodule

// File: rtl/adc_accum_counter.sv
module adc_accum_counter
  import adc_mux_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic [LEN_W-1:0] len_in,
  output logic             acc_end,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] tgt
);
  logic first_frame;
  assign first_frame = frame_start && (cnt == '0);
  assign acc_end     = frame_end && (cnt == tgt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tgt <= LEN_W'(1);
    end else begin
      if (first_frame)
        tgt <= len_in;
      if (frame_end)
        cnt <= acc_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq
  import adc_mux_seq_pkg::*;
#(
  parameter int TICKS  = 13,
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [CH_W-1:0]   chan_sel,
  output logic              sample_vld,
  output logic              frame_irq,
  output logic              accum_irq
);
  logic             frame_start, frame_end, slot_fire, acc_end;
  logic [CH_W-1:0]  slot_ch;
  logic [LEN_W-1:0] acc_cnt, acc_tgt, len_req;

  assign len_req = accum_len(ctrl);

  adc_frame_counter #(.TICKS(TICKS), .NUM_CH(NUM_CH)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .frame_start(frame_start), .frame_end(frame_end),
    .slot_fire(slot_fire), .slot_ch(slot_ch)
  );

  adc_accum_counter u_accum (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .len_in(len_req), .acc_end(acc_end), .cnt(acc_cnt), .tgt(acc_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_sel   <= '0;
      sample_vld <= 1'b0;
      frame_irq  <= 1'b0;
      accum_irq  <= 1'b0;
    end else begin
      sample_vld <= slot_fire;
      if (slot_fire) chan_sel <= slot_ch;
      frame_irq  <= frame_end;
      accum_irq  <= acc_end;
    end
  end
endmodule

// File: rtl/adc_mux_seq_chk.sv
module adc_mux_seq_chk
  import adc_mux_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CH_W-1:0]  chan_sel,
  input logic             sample_vld,
  input logic             frame_irq,
  input logic             accum_irq,
  input logic [LEN_W-1:0] acc_cnt,
  input logic [LEN_W-1:0] acc_tgt
);
  logic [CH_W:0]   vld_seen;
  logic [CH_W-1:0] last_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_seen <= '0;
      last_ch  <= '0;
    end else begin
      if (frame_irq) vld_seen <= '0;
      else if (sample_vld) vld_seen <= vld_seen + 1'b1;
      if (sample_vld) last_ch <= chan_sel;
    end
  end

  a_r5_frame_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);
  a_r5_accum_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    accum_irq |=> !accum_irq);
  a_r4_vld_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_vld) |-> $past(tick));
  a_r10_accum_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    accum_irq |-> frame_irq);
  a_r3_slots_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> vld_seen == (CH_W+1)'(NUM_CH));
  a_r3_chan_order: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && chan_sel != '0) |-> chan_sel == last_ch + 1'b1);
  a_r6_cnt_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt < acc_tgt);
endmodule

bind adc_mux_seq adc_mux_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .chan_sel(chan_sel),
  .sample_vld(sample_vld), .frame_irq(frame_irq), .accum_irq(accum_irq),
  .acc_cnt(acc_cnt), .acc_tgt(acc_tgt)
);

// File: tb/adc_mux_seq_test.sv
module adc_mux_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [1:0] chan_sel;
  logic       sample_vld, frame_irq, accum_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_mux_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl),
    .chan_sel(chan_sel), .sample_vld(sample_vld),
    .frame_irq(frame_irq), .accum_irq(accum_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frames_for(input logic [7:0] c);
    int pre_tab[4] = '{42, 50, 84, 100};
    int s = int'(c[5:0]);
    if (s == 0) s = 1;
    return pre_tab[c[7:6]] * s;
  endfunction

  task automatic do_reset(input logic [7:0] c);
    tick = 1'b0;
    ctrl = c;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_reset();
    do_reset(8'h01);
    check("R1 vld", int'(sample_vld), 0);
    check("R1 chan", int'(chan_sel), 0);
    check("R1 frame_irq", int'(frame_irq), 0);
    check("R1 accum_irq", int'(accum_irq), 0);
    @(negedge clk);
    check("R1 quiet after release", int'(sample_vld | frame_irq | accum_irq), 0);
  endtask

  task automatic test_frame();
    do_reset(8'h01);
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 13; k++) begin
        tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check("R3 slot strobe", int'(sample_vld), (k < 4) ? 1 : 0);
        check("R3 chan order", int'(chan_sel), (k < 4) ? k : 3);
        check("R2 frame end", int'(frame_irq), (k == 12) ? 1 : 0);
        @(negedge clk);
        check("R4 no strobe without tick", int'(sample_vld), 0);
        check("R5 frame_irq one clock", int'(frame_irq), 0);
        check("R4 chan held", int'(chan_sel), (k < 4) ? k : 3);
      end
    end
  endtask

  task automatic run_accum(input string req, input logic [7:0] c0,
                           input logic [7:0] c1, input int change_at,
                           input int exp1, input int exp2);
    int fr = 0, seen = 0, first_at = -1, second_at = -1;
    int total = (exp2 > 0) ? exp2 : exp1;
    do_reset(c0);
    tick = 1'b1;
    while (fr < total + 1) begin
      @(negedge clk);
      if (frame_irq) begin
        fr++;
        if (fr == change_at) ctrl = c1;
      end
      if (accum_irq) begin
        seen++;
        if (!frame_irq) check({req, " R10 accum without frame"}, 0, 1);
        if (seen == 1) first_at = fr;
        if (seen == 2) second_at = fr;
      end else if (seen > 0 && first_at == fr && frame_irq == 1'b0) begin
        first_at = first_at;
      end
    end
    tick = 1'b0;
    @(negedge clk);
    check({req, " first length"}, first_at, exp1);
    if (exp2 > 0) check({req, " second end"}, second_at, exp2);
    else check({req, " single end"}, seen, 1);
    check({req, " R5 accum_irq one clock"}, int'(accum_irq), 0);
  endtask

  initial begin
    test_reset();
    test_frame();
    run_accum("R6 code01 x2", 8'h42, 8'h42, 0, frames_for(8'h42), 0);
    run_accum("R6 code10 x1", 8'h81, 8'h81, 0, frames_for(8'h81), 0);
    run_accum("R7 sum zero", 8'hC0, 8'hC0, 0, 100, 0);
    run_accum("R8 42x50", 8'h32, 8'h32, 0, 2100, 0);
    run_accum("R8 100x21", 8'hD5, 8'hD5, 0, 2100, 0);
    run_accum("R9 mid change", 8'h01, 8'h41, 10, 42, 42 + 50);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule